// File: doc/BRIEF.md
# Event Counter Performance Monitor

This block counts hardware events for a processor core. A set of event counters, their number set by a parameter, each watch one line of an event bus chosen by software. A free-running cycle counter sits beside them and can be slowed to one count per 64 clocks. Software drives everything through a small word-addressed register bus. There is no direct window onto each counter. Software writes a counter index into a select register, and two indirect registers then reach that counter's configuration and value.

Each counter can skip events that arrive while the core runs privileged, or while it runs in user mode. Counter enables and overflow interrupt enables each have a write-one-to-set register and a write-one-to-clear register. When any counter wraps past its all-ones value, its bit in a sticky overflow register is set. The interrupt line is high while any such bit is set and that counter's interrupt is enabled. A read-only 64-bit bitmap reports which event numbers the core implements. Events absent from that bitmap never count. A user-access register decides whether user-mode bus accesses may reach the block at all.

Top module: `pmu_top`

## Requirements
- R1: Reset clears master enable, divide mode, all enables, overflow bits, select, user access, every counter and every counter's configuration, and holds `irq` low. Control (word 0) reads the counter count (parameter NUM_CNT) in bits 15:11, so 4 counters read 0x00002000.
- R2: While control bit 0 (master enable) is 0, no event counter and no cycle counter changes, whatever the event bus does.
- R3: An enabled counter adds one on each clock whose event bus bit, picked by bits 7:0 of its configuration, is 1. Events whose bitmap bit is 0, and event numbers at or above EVT_W, never count.
- R4: Configuration bit 31 set stops counting while `core_priv` is 1. Bit 30 set stops counting while `core_priv` is 0.
- R5: Select (word 6) picks a counter. Configuration (word 7) and value (word 8) then read and write that counter. A select value of NUM_CNT or more reads 0 through words 7 and 8 and ignores writes to them.
- R6: Count-enable set/clear are words 1 and 2, and interrupt-enable set/clear are words 3 and 4. A 1 bit sets or clears, a 0 bit leaves the enable alone, and both words read the current mask. Bit i is counter i, bit 31 is the cycle counter, and other bits stay 0.
- R7: A counter that steps from all ones to zero sets its bit in the overflow word (word 5, cycle counter at bit 31). That bit stays set until a write of 1 to it.
- R8: `irq` is 1 exactly when some overflow bit and the matching interrupt-enable bit are both 1.
- R9: A bus write to a counter value in the same clock as an event increment stores the written value, and the increment is lost.
- R10: The cycle counter (word 9) adds one per clock when master enable and enable bit 31 are set. With control bit 3 set, it adds one per 64 enabled clocks. Writing it also restarts the 64-clock divider.
- R11: Words 10 and 11 read the implemented-event bitmap (event n at word 10+n/32, bit n%32) and ignore writes.
- R12: The user-access register (word 12, bit 0) resets to 0. While it is 0, bus accesses with `bus_priv` = 0 read 0 and change nothing. It can only be written with `bus_priv` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_priv | input | 1 | Access comes from privileged mode |
| bus_rdata | output | 32 | Read data, combinational, 0 when no permitted read |
| core_priv | input | 1 | Core currently in privileged mode |
| evt_bus | input | EVT_W | One line per event number |
| irq | output | 1 | Overflow interrupt request |

## Verification
The checker assumes that `bus_valid` and the fields that go with it are steady around each clock edge. It also assumes that `evt_bus` and `core_priv` are sampled only at edges, so at most one increment per counter per clock is possible. The bench changes every input just after a falling edge and samples read data shortly after that. Random event patterns run only while the bus is idle, so the bench's own per-clock count model never has to line up bus writes with increments. The write-versus-increment collision is covered by a separate directed case.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
   localparam int DATA_W = 32;
   localparam int SEL_W  = 5;

   localparam logic [3:0] RA_CTRL    = 4'd0;
   localparam logic [3:0] RA_EN_SET  = 4'd1;
   localparam logic [3:0] RA_EN_CLR  = 4'd2;
   localparam logic [3:0] RA_IE_SET  = 4'd3;
   localparam logic [3:0] RA_IE_CLR  = 4'd4;
   localparam logic [3:0] RA_OVF     = 4'd5;
   localparam logic [3:0] RA_SEL     = 4'd6;
   localparam logic [3:0] RA_TYPE    = 4'd7;
   localparam logic [3:0] RA_VALUE   = 4'd8;
   localparam logic [3:0] RA_CYCLE   = 4'd9;
   localparam logic [3:0] RA_IMPL_LO = 4'd10;
   localparam logic [3:0] RA_IMPL_HI = 4'd11;
   localparam logic [3:0] RA_UACC    = 4'd12;

   localparam int CYC_IDX = 31;

   typedef struct packed {
      logic       excl_priv;
      logic       excl_user;
      logic [7:0] evsel;
   } evt_cfg_t;
endpackage

// File: rtl/pmu_event_counter.sv
module pmu_event_counter
   import pmu_pkg::*;
#(
   parameter int CNT_W = 32,
   parameter int EVT_W = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             count_ok,
   input  logic             core_priv,
   input  logic [EVT_W-1:0] evt_bus,
   input  logic             cfg_we,
   input  evt_cfg_t         cfg_wdata,
   input  logic             val_we,
   input  logic [CNT_W-1:0] val_wdata,
   output evt_cfg_t         cfg,
   output logic [CNT_W-1:0] value,
   output logic             wrap
);
   localparam logic [CNT_W-1:0] CNT_ONE = 1;

   evt_cfg_t         cfg_q;
   logic [CNT_W-1:0] value_q;
   logic             hit;
   logic             mode_ok;
   logic             inc;

   always_comb begin
      hit = 1'b0;
      for (int e = 0; e < EVT_W; e++) begin
         if (cfg_q.evsel == 8'(e)) hit = evt_bus[e];
      end
   end

   assign mode_ok = core_priv ? !cfg_q.excl_priv : !cfg_q.excl_user;
   assign inc     = count_ok && hit && mode_ok;
   assign wrap    = inc && !val_we && (&value_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q   <= '0;
         value_q <= '0;
      end else begin
         if (cfg_we) cfg_q <= cfg_wdata;
         if (val_we)   value_q <= val_wdata;
         else if (inc) value_q <= value_q + CNT_ONE;
      end
   end

   assign cfg   = cfg_q;
   assign value = value_q;
endmodule

// File: rtl/pmu_cycle_counter.sv
module pmu_cycle_counter #(
   parameter int CNT_W    = 32,
   parameter int DIV_LOG2 = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             div_mode,
   input  logic             we,
   input  logic [CNT_W-1:0] wdata,
   output logic [CNT_W-1:0] value,
   output logic             wrap
);
   localparam logic [CNT_W-1:0] CNT_ONE = 1;

   logic             tick;
   logic [CNT_W-1:0] value_q;

   generate
      if (DIV_LOG2 == 0) begin : g_nodiv
         logic unused_div;
         assign unused_div = div_mode;
         assign tick = run;
      end else begin : g_div
         localparam logic [DIV_LOG2-1:0] PRE_ONE = 1;
         logic [DIV_LOG2-1:0] pre_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                pre_q <= '0;
            else if (we)               pre_q <= '0;
            else if (run && div_mode)  pre_q <= pre_q + PRE_ONE;
         end
         assign tick = run && (!div_mode || (&pre_q));
      end
   endgenerate

   assign wrap = tick && !we && (&value_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    value_q <= '0;
      else if (we)   value_q <= wdata;
      else if (tick) value_q <= value_q + CNT_ONE;
   end

   assign value = value_q;
endmodule

// File: rtl/pmu_top.sv
module pmu_top
   import pmu_pkg::*;
#(
   parameter int          NUM_CNT  = 4,
   parameter int          CNT_W    = 32,
   parameter int          EVT_W    = 64,
   parameter int          DIV_LOG2 = 6,
   parameter logic [63:0] IMPL_MAP = 64'h0FFF_FFFF_FFFF_7FFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [3:0]        bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_priv,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              core_priv,
   input  logic [EVT_W-1:0]  evt_bus,
   output logic              irq
);
   localparam logic [DATA_W-1:0] CNT_MASK   = (DATA_W'(1) << NUM_CNT) - DATA_W'(1);
   localparam logic [DATA_W-1:0] VALID_MASK = CNT_MASK | (DATA_W'(1) << CYC_IDX);
   localparam logic [4:0]        NCNT_FLD   = 5'(NUM_CNT);

   initial begin
      assert (NUM_CNT >= 1 && NUM_CNT <= 31) else $error("NUM_CNT out of range");
      assert (CNT_W >= 2 && CNT_W <= DATA_W) else $error("CNT_W out of range");
      assert (EVT_W >= 1 && EVT_W <= 64) else $error("EVT_W out of range");
      assert (DIV_LOG2 >= 0 && DIV_LOG2 <= 16) else $error("DIV_LOG2 out of range");
   end

   logic              ctrl_en_q, ctrl_div_q, uacc_q;
   logic [DATA_W-1:0] en_q, ie_q, ovf_q, ovf_next, wrap_vec;
   logic [SEL_W-1:0]  sel_q;
   logic              acc_ok, wr, rd;
   logic              type_we, val_we, cyc_we;
   evt_cfg_t          cfg_wd, sel_cfg;
   logic [EVT_W-1:0]  evt_live;
   logic [CNT_W-1:0]  sel_val, cyc_val;
   logic              cyc_wrap;
   evt_cfg_t          cfg_a  [NUM_CNT];
   logic [CNT_W-1:0]  val_a  [NUM_CNT];
   logic [NUM_CNT-1:0] cnt_wrap;

   assign acc_ok   = bus_priv || uacc_q;
   assign wr       = bus_valid && bus_write && acc_ok;
   assign rd       = bus_valid && !bus_write && acc_ok;
   assign type_we  = wr && (bus_addr == RA_TYPE);
   assign val_we   = wr && (bus_addr == RA_VALUE);
   assign cyc_we   = wr && (bus_addr == RA_CYCLE);
   assign evt_live = evt_bus & IMPL_MAP[EVT_W-1:0];
   assign cfg_wd   = '{excl_priv: bus_wdata[31], excl_user: bus_wdata[30], evsel: bus_wdata[7:0]};

   generate
      for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
         pmu_event_counter #(.CNT_W(CNT_W), .EVT_W(EVT_W)) u_cnt (
            .clk       (clk),
            .rst_n     (rst_n),
            .count_ok  (ctrl_en_q && en_q[i]),
            .core_priv (core_priv),
            .evt_bus   (evt_live),
            .cfg_we    (type_we && (sel_q == SEL_W'(i))),
            .cfg_wdata (cfg_wd),
            .val_we    (val_we && (sel_q == SEL_W'(i))),
            .val_wdata (bus_wdata[CNT_W-1:0]),
            .cfg       (cfg_a[i]),
            .value     (val_a[i]),
            .wrap      (cnt_wrap[i])
         );
      end
   endgenerate

   pmu_cycle_counter #(.CNT_W(CNT_W), .DIV_LOG2(DIV_LOG2)) u_cyc (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (ctrl_en_q && en_q[CYC_IDX]),
      .div_mode (ctrl_div_q),
      .we       (cyc_we),
      .wdata    (bus_wdata[CNT_W-1:0]),
      .value    (cyc_val),
      .wrap     (cyc_wrap)
   );

   always_comb begin
      wrap_vec = '0;
      wrap_vec[NUM_CNT-1:0] = cnt_wrap;
      wrap_vec[CYC_IDX] = cyc_wrap;
      ovf_next = ovf_q;
      if (wr && bus_addr == RA_OVF) ovf_next = ovf_next & ~bus_wdata;
      ovf_next = (ovf_next | wrap_vec) & VALID_MASK;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_en_q  <= 1'b0;
         ctrl_div_q <= 1'b0;
         en_q       <= '0;
         ie_q       <= '0;
         ovf_q      <= '0;
         sel_q      <= '0;
         uacc_q     <= 1'b0;
      end else begin
         ovf_q <= ovf_next;
         if (wr) begin
            case (bus_addr)
               RA_CTRL: begin
                  ctrl_en_q  <= bus_wdata[0];
                  ctrl_div_q <= bus_wdata[3];
               end
               RA_EN_SET: en_q  <= (en_q | bus_wdata) & VALID_MASK;
               RA_EN_CLR: en_q  <= en_q & ~bus_wdata;
               RA_IE_SET: ie_q  <= (ie_q | bus_wdata) & VALID_MASK;
               RA_IE_CLR: ie_q  <= ie_q & ~bus_wdata;
               RA_SEL:    sel_q <= bus_wdata[SEL_W-1:0];
               RA_UACC:   if (bus_priv) uacc_q <= bus_wdata[0];
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      sel_cfg = '0;
      sel_val = '0;
      for (int i = 0; i < NUM_CNT; i++) begin
         if (sel_q == SEL_W'(i)) begin
            sel_cfg = cfg_a[i];
            sel_val = val_a[i];
         end
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (rd) begin
         case (bus_addr)
            RA_CTRL:    bus_rdata = {16'b0, NCNT_FLD, 7'b0, ctrl_div_q, 2'b0, ctrl_en_q};
            RA_EN_SET,
            RA_EN_CLR:  bus_rdata = en_q;
            RA_IE_SET,
            RA_IE_CLR:  bus_rdata = ie_q;
            RA_OVF:     bus_rdata = ovf_q;
            RA_SEL:     bus_rdata[SEL_W-1:0] = sel_q;
            RA_TYPE:    bus_rdata = {sel_cfg.excl_priv, sel_cfg.excl_user, 22'b0, sel_cfg.evsel};
            RA_VALUE:   bus_rdata[CNT_W-1:0] = sel_val;
            RA_CYCLE:   bus_rdata[CNT_W-1:0] = cyc_val;
            RA_IMPL_LO: bus_rdata = IMPL_MAP[31:0];
            RA_IMPL_HI: bus_rdata = IMPL_MAP[63:32];
            RA_UACC:    bus_rdata[0] = uacc_q;
            default:    bus_rdata = '0;
         endcase
      end
   end

   assign irq = |(ovf_q & ie_q);
endmodule

// File: rtl/pmu_top_checker.sv
module pmu_top_checker
   import pmu_pkg::*;
#(
   parameter int NUM_CNT = 4,
   parameter int CNT_W   = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_valid,
   input logic              bus_write,
   input logic [3:0]        bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              bus_priv,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              irq,
   input logic              ctrl_en_q,
   input logic [DATA_W-1:0] en_q,
   input logic [DATA_W-1:0] ie_q,
   input logic [DATA_W-1:0] ovf_q,
   input logic [SEL_W-1:0]  sel_q,
   input logic              uacc_q,
   input logic [CNT_W-1:0]  cyc_val
);
   logic any_wr, ovf_wr, ie_clr_wr, cyc_wr, en_wr;
   assign any_wr    = bus_valid && bus_write;
   assign ovf_wr    = any_wr && bus_addr == RA_OVF;
   assign ie_clr_wr = any_wr && bus_addr == RA_IE_CLR;
   assign cyc_wr    = any_wr && bus_addr == RA_CYCLE;
   assign en_wr     = any_wr && (bus_addr == RA_EN_SET || bus_addr == RA_EN_CLR);

   assert_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_en_q && !cyc_wr) |=> $stable(cyc_val));

   assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q != '0 && !ovf_wr) |=> ((ovf_q & $past(ovf_q)) == $past(ovf_q)));

   assert_irq_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !ovf_wr && !ie_clr_wr) |=> irq);

   assert_user_block_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (any_wr && !bus_priv && !uacc_q) |=>
         ($stable(en_q) && $stable(ie_q) && $stable(sel_q) && $stable(uacc_q) && $stable(ctrl_en_q)));

   assert_zero_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (en_wr && bus_wdata == '0) |=> $stable(en_q));

   assert_sel_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_write && (bus_priv || uacc_q) &&
       (bus_addr == RA_TYPE || bus_addr == RA_VALUE) && int'(sel_q) >= NUM_CNT) |-> bus_rdata == '0);
endmodule

bind pmu_top pmu_top_checker #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W)) u_pmu_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_valid (bus_valid),
   .bus_write (bus_write),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_priv  (bus_priv),
   .bus_rdata (bus_rdata),
   .irq       (irq),
   .ctrl_en_q (ctrl_en_q),
   .en_q      (en_q),
   .ie_q      (ie_q),
   .ovf_q     (ovf_q),
   .sel_q     (sel_q),
   .uacc_q    (uacc_q),
   .cyc_val   (cyc_val)
);

// File: tb/pmu_top_bench.sv
module pmu_top_bench;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int          NC   = 4;
   localparam logic [63:0] IMPL = 64'h0FFF_FFFF_FFFF_7FFF;
   localparam logic [3:0] A_CTRL = 0, A_ENS = 1, A_ENC = 2, A_IES = 3, A_IEC = 4, A_OVF = 5,
                          A_SEL = 6, A_TYPE = 7, A_VAL = 8, A_CYC = 9, A_ILO = 10, A_IHI = 11, A_UACC = 12;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0, bus_write = 1'b0, bus_priv = 1'b1;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        core_priv = 1'b0;
   logic [63:0] evt_bus = '0;
   logic        irq;

   int nchk = 0, nerr = 0;
   logic [7:0]  m_ev [NC];
   logic        m_xp [NC], m_xu [NC];
   logic [31:0] m_cnt [NC];
   logic [31:0] m_ovf;
   logic [31:0] m_en;
   logic        m_men;
   logic [31:0] rv;

   pmu_top #(.NUM_CNT(NC), .CNT_W(32), .EVT_W(64), .DIV_LOG2(6), .IMPL_MAP(IMPL)) u_pmu_top (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_priv(bus_priv),
      .bus_rdata(bus_rdata), .core_priv(core_priv), .evt_bus(evt_bus), .irq(irq));

   always #2.5 clk = ~clk;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic pv = 1'b1);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d; bus_priv = pv;
      @(posedge clk);
      #1 bus_valid = 1'b0; bus_write = 1'b0; bus_priv = 1'b1;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d, input logic pv = 1'b1);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_priv = pv;
      #1 d = bus_rdata;
      bus_valid = 1'b0; bus_priv = 1'b1;
   endtask

   function automatic logic counts(input int i, input logic [63:0] ev, input logic pv);
      logic [63:0] live = ev & IMPL;
      if (!m_men || !m_en[i]) return 1'b0;
      if (pv ? m_xp[i] : m_xu[i]) return 1'b0;
      if (m_ev[i] >= 8'd64) return 1'b0;
      return live[m_ev[i][5:0]];
   endfunction

   task automatic set_cfg(input int i, input logic [7:0] ev, input logic xp, input logic xu);
      wr(A_SEL, 32'(i));
      wr(A_TYPE, {xp, xu, 22'b0, ev});
      m_ev[i] = ev; m_xp[i] = xp; m_xu[i] = xu;
   endtask

   task automatic set_val(input int i, input logic [31:0] v);
      wr(A_SEL, 32'(i));
      wr(A_VAL, v);
      m_cnt[i] = v;
   endtask

   task automatic get_val(input int i, output logic [31:0] v);
      wr(A_SEL, 32'(i));
      rd(A_VAL, v);
   endtask

   task automatic run(input int n, input logic rnd, input logic [63:0] ev, input logic pv);
      for (int c = 0; c < n; c++) begin
         @(negedge clk);
         evt_bus   = rnd ? {$urandom(), $urandom()} : ev;
         core_priv = rnd ? 1'($urandom()) : pv;
         for (int i = 0; i < NC; i++) begin
            if (counts(i, evt_bus, core_priv)) begin
               m_cnt[i] = m_cnt[i] + 1;
               if (m_cnt[i] == 0) m_ovf[i] = 1'b1;
            end
         end
      end
      @(negedge clk);
      evt_bus = '0;
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      finish_run();
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < NC; i++) begin
         m_ev[i] = '0; m_xp[i] = 1'b0; m_xu[i] = 1'b0; m_cnt[i] = '0;
      end
      m_ovf = '0; m_en = '0; m_men = 1'b0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      rd(A_CTRL, rv); check("R1 ctrl", rv, 32'h0000_2000);
      rd(A_ENS, rv);  check("R1 count enables", rv, 32'h0);
      rd(A_IES, rv);  check("R1 irq enables", rv, 32'h0);
      rd(A_OVF, rv);  check("R1 overflow", rv, 32'h0);
      rd(A_SEL, rv);  check("R1 select", rv, 32'h0);
      rd(A_VAL, rv);  check("R1 counter 0", rv, 32'h0);
      rd(A_CYC, rv);  check("R1 cycle", rv, 32'h0);
      rd(A_UACC, rv); check("R1 user access", rv, 32'h0);
      check("R1 irq", {31'b0, irq}, 32'h0);

      // R11 implemented bitmap
      rd(A_ILO, rv); check("R11 bitmap low", rv, IMPL[31:0]);
      rd(A_IHI, rv); check("R11 bitmap high", rv, IMPL[63:32]);
      wr(A_ILO, 32'h0);
      rd(A_ILO, rv); check("R11 bitmap write ignored", rv, IMPL[31:0]);

      // R12 user access gating
      rd(A_CTRL, rv, 1'b0); check("R12 user read blocked", rv, 32'h0);
      wr(A_ENS, 32'h1, 1'b0);
      rd(A_ENS, rv); check("R12 user write blocked", rv, 32'h0);
      wr(A_UACC, 32'h1, 1'b0);
      rd(A_UACC, rv); check("R12 user cannot open access", rv, 32'h0);
      wr(A_UACC, 32'h1);
      rd(A_CTRL, rv, 1'b0); check("R12 user read allowed", rv, 32'h0000_2000);
      wr(A_UACC, 32'h1, 1'b0);
      wr(A_UACC, 32'h0, 1'b0);
      rd(A_UACC, rv); check("R12 user write to access reg ignored", rv, 32'h1);
      wr(A_UACC, 32'h0);

      // R6 set/clear enables
      wr(A_ENS, 32'h5);
      rd(A_ENS, rv); check("R6 set", rv, 32'h5);
      rd(A_ENC, rv); check("R6 clear word reads mask", rv, 32'h5);
      wr(A_ENC, 32'h1);
      rd(A_ENS, rv); check("R6 clear one", rv, 32'h4);
      wr(A_ENS, 32'h0);
      rd(A_ENS, rv); check("R6 zero write keeps", rv, 32'h4);
      wr(A_ENS, 32'hFFFF_FFFF);
      rd(A_ENS, rv); check("R6 reserved bits stay 0", rv, 32'h8000_000F);
      wr(A_ENC, 32'hFFFF_FFFF);
      rd(A_ENS, rv); check("R6 clear all", rv, 32'h0);
      wr(A_IES, 32'h0000_0402);
      rd(A_IEC, rv); check("R6 irq enable set", rv, 32'h2);
      wr(A_IEC, 32'h2);

      // R5 out-of-range select
      set_cfg(0, 8'd9, 1'b0, 1'b0);
      wr(A_SEL, 32'd7);
      wr(A_TYPE, 32'hC000_0011);
      wr(A_VAL, 32'h1234);
      rd(A_TYPE, rv); check("R5 out-of-range type reads 0", rv, 32'h0);
      rd(A_VAL, rv);  check("R5 out-of-range value reads 0", rv, 32'h0);
      rd(A_SEL, rv);  check("R5 select readback", rv, 32'd7);
      wr(A_SEL, 32'd0);
      rd(A_TYPE, rv); check("R5 counter 0 config kept", rv, 32'h0000_0009);
      rd(A_VAL, rv);  check("R5 counter 0 value kept", rv, 32'h0);

      // R2 master enable off: nothing counts
      wr(A_ENS, 32'hF); m_en = 32'hF;
      run(30, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
      get_val(0, rv); check("R2 no count while master off", rv, 32'h0);

      // R3 basic, unimplemented, out of range
      wr(A_CTRL, 32'h1); m_men = 1'b1;
      set_cfg(0, 8'd3, 1'b0, 1'b0);
      set_cfg(1, 8'd15, 1'b0, 1'b0);
      set_cfg(2, 8'd200, 1'b0, 1'b0);
      set_cfg(3, 8'd4, 1'b0, 1'b0);
      run(12, 1'b0, 64'h0000_0000_0000_8008, 1'b1);
      get_val(0, rv); check("R3 selected event counts", rv, 32'd12);
      get_val(1, rv); check("R3 unimplemented event ignored", rv, 32'd0);
      get_val(2, rv); check("R3 event number beyond bus ignored", rv, 32'd0);
      get_val(3, rv); check("R3 other event line ignored", rv, 32'd0);

      // R4 privilege filter
      set_cfg(1, 8'd5, 1'b1, 1'b0);
      set_cfg(2, 8'd5, 1'b0, 1'b1);
      set_val(1, 0); set_val(2, 0);
      run(7, 1'b0, 64'h20, 1'b1);
      run(5, 1'b0, 64'h20, 1'b0);
      get_val(1, rv); check("R4 privileged excluded", rv, 32'd5);
      get_val(2, rv); check("R4 user excluded", rv, 32'd7);

      // R9 write beats increment
      wr(A_SEL, 32'd0);
      @(negedge clk); evt_bus = 64'h8;
      wr(A_VAL, 32'd100);
      rd(A_VAL, rv); evt_bus = '0;
      check("R9 write wins over increment", rv, 32'd100);
      m_cnt[0] = 32'd100;

      // R7 / R8 overflow and interrupt
      set_val(3, 32'hFFFF_FFFE);
      run(2, 1'b0, 64'h10, 1'b1);
      get_val(3, rv); check("R7 counter wrapped to 0", rv, 32'h0);
      rd(A_OVF, rv);  check("R7 overflow bit set", rv, 32'h8);
      check("R8 irq low while disabled", {31'b0, irq}, 32'h0);
      wr(A_IES, 32'h8);
      #1 check("R8 irq high when enabled", {31'b0, irq}, 32'h1);
      repeat (3) @(posedge clk);
      rd(A_OVF, rv); check("R7 overflow sticky", rv, 32'h8);
      wr(A_OVF, 32'h1);
      rd(A_OVF, rv); check("R7 write 1 elsewhere keeps bit", rv, 32'h8);
      wr(A_OVF, 32'h8);
      rd(A_OVF, rv); check("R7 write 1 clears", rv, 32'h0);
      #1 check("R8 irq low after clear", {31'b0, irq}, 32'h0);
      wr(A_IEC, 32'hFFFF_FFFF);
      m_ovf = '0;

      // R10 cycle counter
      wr(A_ENC, 32'hF); m_en = 32'h0;
      wr(A_CYC, 32'h0);
      wr(A_ENS, 32'h8000_0000);
      rd(A_CYC, rv); check("R10 cycle starts at 0", rv, 32'd0);
      repeat (10) @(posedge clk);
      rd(A_CYC, rv); check("R10 counts each clock", rv, 32'd10);
      wr(A_ENC, 32'h8000_0000);
      repeat (5) @(posedge clk);
      rd(A_CYC, rv); check("R10 stops when disabled", rv, 32'd12);
      wr(A_CTRL, 32'h9);
      wr(A_CYC, 32'h0);
      wr(A_ENS, 32'h8000_0000);
      repeat (128) @(posedge clk);
      rd(A_CYC, rv); check("R10 divide by 64 after 128 clocks", rv, 32'd2);
      repeat (63) @(posedge clk);
      rd(A_CYC, rv); check("R10 divide edge 191 clocks", rv, 32'd2);
      @(posedge clk);
      rd(A_CYC, rv); check("R10 divide edge 192 clocks", rv, 32'd3);
      wr(A_ENC, 32'h8000_0000);
      wr(A_CTRL, 32'h1);

      // Random rounds: R3, R4, R7, then R2 with master off
      for (int r = 0; r < 4; r++) begin
         for (int i = 0; i < NC; i++) begin
            set_cfg(i, 8'($urandom_range(63)), 1'($urandom()), 1'($urandom()));
            set_val(i, 32'hFFFF_FFFF - 32'($urandom_range(60)));
         end
         m_en = 32'($urandom_range(15)) | 32'h1;
         wr(A_ENC, 32'hF); wr(A_ENS, m_en);
         m_men = (r != 3);
         wr(A_CTRL, {31'b0, m_men});
         run(150, 1'b1, '0, 1'b0);
         for (int i = 0; i < NC; i++) begin
            get_val(i, rv);
            check(m_men ? "R3 random count" : "R2 random count while off", rv, m_cnt[i]);
         end
         rd(A_OVF, rv); check("R7 random overflow", rv, m_ovf);
         wr(A_OVF, 32'hFFFF_FFFF); m_ovf = '0;
         rd(A_OVF, rv); check("R7 random overflow cleared", rv, 32'h0);
      end

      finish_run();
   end
endmodule